// File: doc/BRIEF.md
# Descriptor-Chained Byte DMA Engine

This block is a bus master that copies bytes between a byte-wide peripheral data port and system memory, in either direction. A processor programs it through a small register window of six registers. Once the command value is written, the engine runs on its own and raises an optional completion interrupt.

There are two ways to describe a transfer. The first is a single run given by an address register and a count register. The second is a chain of two-word descriptors in memory that the engine fetches one by one. Each descriptor holds a start address followed by a count word. In the count word, bits 23:0 are the byte length, bits 26:24 are the bus function code, and bit 31 says whether another descriptor follows.

Every memory cycle carries a function code on a side output. Data cycles use the code of the current segment, and descriptor fetches use a separate table function-code register. Faults stop the transfer and leave the address and remaining count readable for diagnosis. These faults are a bus error on a fetch, a bus error on a data access, a zero-length segment and a misaligned table pointer.

Top module: `dma_sg_engine`

Register map (`reg_addr`):
- 0: control and status
- 1: segment address
- 2: segment count
- 3: table pointer
- 4: table function code
- 5: interrupt control

Control and status register bits:
- Write bits: 0 = start, 1 = direction (1 means memory to peripheral), 2 = table mode.
- Read bits: 0 = busy, 1 = direction, 2 = table mode, 3 = done, 4 = fetch bus error, 5 = data bus error, 6 = size error, 7 = alignment error.

Interrupt control register bits: bit 0 = pending (writing 1 acknowledges), bit 1 = enable, bits 4:2 = level.

## Requirements
- R1: After reset every register reads zero, `irq` is low, and neither `mem_req` nor `per_req` is asserted.
- R2: In direct mode (control bit 2 clear) the engine moves the number of bytes in segment-count bits 23:0, starting at the segment address and in ascending address order. Direction bit 1 set moves memory to the peripheral; clear moves the peripheral to memory. At the end, the address register reads start plus length and the length field reads zero.
- R3: In table mode the engine reads descriptors at ascending word addresses from the table pointer: the address word first, then the count word. It stops after the first descriptor whose bit 31 is clear and makes no further memory access.
- R4: Data cycles drive `mem_fc` with the segment function code (count bits 26:24). Descriptor fetch cycles (`mem_word` high) drive the table function-code register bits 2:0.
- R5: When the last byte of the last segment completes, status bit 3 (done) sets and bit 0 (busy) reads zero.
- R6: Completion sets the pending bit only while interrupt enable (bit 1) is set. `irq` follows the pending bit, and `irq_lvl` follows bits 4:2. Writing the interrupt register with bit 0 set clears the pending bit.
- R7: A bus error on a data access aborts the transfer and sets status bits 5 and 3. The address register then reads the faulting address, and the length field reads the bytes not yet moved, counting the faulting one.
- R8: A bus error on a descriptor fetch aborts the transfer and sets status bits 4 and 3, with no data access.
- R9: A segment of length zero sets status bits 6 and 3 and makes no data access.
- R10: A table-mode start with table pointer bits 1:0 not zero sets status bits 7 and 3 and makes no memory access.
- R11: Writing zero to the control register stops an active transfer at once. No further request is made, done stays clear, and no interrupt is raised.
- R12: Any write to the control register clears the done and error flags.
- R13: `mem_req` and `per_req` are never high together. A memory request holds its address until acknowledged, unless the control register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_addr`) |
| mem_req | output | 1 | Memory cycle request, held until `mem_ack` |
| mem_we | output | 1 | Memory write (byte) |
| mem_word | output | 1 | 32-bit descriptor fetch cycle |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_fc | output | 3 | Bus function code of the cycle |
| mem_ack | input | 1 | Memory cycle complete |
| mem_err | input | 1 | Bus error, valid with `mem_ack` |
| mem_rdata | input | 32 | Memory read data, byte in bits 7:0 |
| per_req | output | 1 | Peripheral byte request |
| per_we | output | 1 | Write byte to the peripheral |
| per_wdata | output | 8 | Byte to the peripheral |
| per_rdata | input | 8 | Byte from the peripheral |
| per_ack | input | 1 | Peripheral cycle complete |
| irq | output | 1 | Interrupt request |
| irq_lvl | output | 3 | Interrupt priority level |

## Verification
The hardest state to reach is a fault in the middle of a chain or a segment. Only then do the live address and remaining count carry meaning, and only then must the walk stop short of descriptors still in memory. The bench memory model returns a bus error when the engine touches one chosen address. Placing that address inside a data run, or on a descriptor's count word, drives the engine into each abort path at a known byte. A fourth valid descriptor placed after the terminating one, together with a count of memory cycles, shows that the walk ends at the cleared continuation bit.

// File: rtl/dma_sg_pkg.sv
package dma_sg_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int LEN_W  = 24;
    localparam int FC_W   = 3;
    localparam int LVL_W  = 3;
    localparam int RA_W   = 3;

    localparam logic [RA_W-1:0] RA_CTRL  = 3'd0;
    localparam logic [RA_W-1:0] RA_DADDR = 3'd1;
    localparam logic [RA_W-1:0] RA_DCNT  = 3'd2;
    localparam logic [RA_W-1:0] RA_TADDR = 3'd3;
    localparam logic [RA_W-1:0] RA_TFC   = 3'd4;
    localparam logic [RA_W-1:0] RA_IRQ   = 3'd5;

    typedef enum logic [3:0] {
        S_IDLE, S_FETCH_A, S_FETCH_C, S_CHECK,
        S_MRD, S_PWR, S_PRD, S_MWR, S_SEGEND
    } seq_state_e;

    // status flags, read back in control bits 7:3
    typedef struct packed {
        logic narrow;
        logic size;
        logic dberr;
        logic tberr;
        logic done;
    } dma_flags_t;

    typedef struct packed {
        logic tbl;
        logic dir;
    } dma_mode_t;

    function automatic logic [FC_W-1:0] cnt_fc(input logic [DATA_W-1:0] w);
        return w[LEN_W +: FC_W];
    endfunction

    function automatic logic [LEN_W-1:0] cnt_len(input logic [DATA_W-1:0] w);
        return w[LEN_W-1:0];
    endfunction
endpackage

// File: rtl/dma_sg_irq.sv
module dma_sg_irq
    import dma_sg_pkg::*;
#(
    parameter int LW = LVL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [LW+1:0] wdata,
    input  logic          done_pulse,
    output logic [LW+1:0] rdata,
    output logic          irq,
    output logic [LW-1:0] irq_lvl
);
    logic          pend_q;
    logic          ie_q;
    logic [LW-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            ie_q   <= 1'b0;
            lvl_q  <= '0;
        end else begin
            if (wr) begin
                ie_q  <= wdata[1];
                lvl_q <= wdata[LW+1:2];
            end
            // a completion in the same cycle as an acknowledge wins
            if (done_pulse && ie_q)
                pend_q <= 1'b1;
            else if (wr && wdata[0])
                pend_q <= 1'b0;
        end
    end

    assign rdata   = {lvl_q, ie_q, pend_q};
    assign irq     = pend_q;
    assign irq_lvl = lvl_q;

    p_pend_needs_ie_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(pend_q) |-> $past(ie_q));
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (rst)
        (wr && wdata[0] && !done_pulse) |=> !pend_q);
endmodule

// File: rtl/dma_sg_seq.sv
module dma_sg_seq
    import dma_sg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int LW = LEN_W,
    parameter int FW = FC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctrl_wr,
    input  logic [2:0]    ctrl_val,
    input  logic          daddr_wr,
    input  logic          dcnt_wr,
    input  logic          taddr_wr,
    input  logic [DW-1:0] wdata,
    input  logic [FW-1:0] tfc,
    output dma_flags_t    flags,
    output dma_mode_t     mode,
    output logic          busy,
    output logic [AW-1:0] daddr,
    output logic [LW-1:0] len,
    output logic [FW-1:0] seg_fc,
    output logic [AW-1:0] taddr,
    output logic          done_pulse,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_word,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic [FW-1:0] mem_fc,
    input  logic          mem_ack,
    input  logic          mem_err,
    input  logic [DW-1:0] mem_rdata,
    output logic          per_req,
    output logic          per_we,
    output logic [7:0]    per_wdata,
    input  logic [7:0]    per_rdata,
    input  logic          per_ack
);
    localparam logic [AW-1:0] WORD_STEP = AW'(DW / 8);
    localparam logic [LW-1:0] ONE_LEFT  = LW'(1);

    seq_state_e    st_q;
    logic [AW-1:0] daddr_q, taddr_q, tptr_q;
    logic [LW-1:0] len_q;
    logic [FW-1:0] fc_q;
    logic          more_q;
    logic [7:0]    byte_q;
    dma_flags_t    flags_q;
    dma_mode_t     mode_q;

    logic fetching, start_bad, last_end, bus_fault, zero_seg;

    assign fetching  = (st_q == S_FETCH_A) || (st_q == S_FETCH_C);
    assign mem_req   = fetching || (st_q == S_MRD) || (st_q == S_MWR);
    assign mem_we    = (st_q == S_MWR);
    assign mem_word  = fetching;
    assign mem_addr  = fetching ? tptr_q : daddr_q;
    assign mem_fc    = fetching ? tfc : fc_q;
    assign mem_wdata = byte_q;
    assign per_req   = (st_q == S_PWR) || (st_q == S_PRD);
    assign per_we    = (st_q == S_PWR);
    assign per_wdata = byte_q;

    assign start_bad = ctrl_wr && ctrl_val[0] && ctrl_val[2] && (taddr_q[1:0] != 2'b00);
    assign last_end  = (st_q == S_SEGEND) && !(mode_q.tbl && more_q);
    assign bus_fault = mem_req && mem_ack && mem_err;
    assign zero_seg  = (st_q == S_CHECK) && (len_q == '0);
    assign done_pulse = start_bad || (!ctrl_wr && (last_end || bus_fault || zero_seg));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= S_IDLE;
            daddr_q <= '0;
            taddr_q <= '0;
            tptr_q  <= '0;
            len_q   <= '0;
            fc_q    <= '0;
            more_q  <= 1'b0;
            byte_q  <= '0;
            flags_q <= '0;
            mode_q  <= '0;
        end else if (ctrl_wr) begin
            mode_q  <= '{tbl: ctrl_val[2], dir: ctrl_val[1]};
            flags_q <= '0;
            tptr_q  <= taddr_q;
            if (!ctrl_val[0]) begin
                st_q <= S_IDLE;
            end else if (start_bad) begin
                flags_q.narrow <= 1'b1;
                flags_q.done   <= 1'b1;
                st_q           <= S_IDLE;
            end else begin
                st_q <= ctrl_val[2] ? S_FETCH_A : S_CHECK;
            end
        end else begin
            if (daddr_wr) daddr_q <= wdata[AW-1:0];
            if (dcnt_wr) begin
                len_q <= cnt_len(wdata);
                fc_q  <= cnt_fc(wdata);
            end
            if (taddr_wr) taddr_q <= wdata[AW-1:0];
            case (st_q)
                S_FETCH_A: if (mem_ack) begin
                    if (mem_err) begin
                        flags_q.tberr <= 1'b1;
                        flags_q.done  <= 1'b1;
                        st_q          <= S_IDLE;
                    end else begin
                        daddr_q <= mem_rdata[AW-1:0];
                        tptr_q  <= tptr_q + WORD_STEP;
                        st_q    <= S_FETCH_C;
                    end
                end
                S_FETCH_C: if (mem_ack) begin
                    if (mem_err) begin
                        flags_q.tberr <= 1'b1;
                        flags_q.done  <= 1'b1;
                        st_q          <= S_IDLE;
                    end else begin
                        len_q  <= cnt_len(mem_rdata);
                        fc_q   <= cnt_fc(mem_rdata);
                        more_q <= mem_rdata[DW-1];
                        tptr_q <= tptr_q + WORD_STEP;
                        st_q   <= S_CHECK;
                    end
                end
                S_CHECK: begin
                    if (len_q == '0) begin
                        flags_q.size <= 1'b1;
                        flags_q.done <= 1'b1;
                        st_q         <= S_IDLE;
                    end else begin
                        st_q <= mode_q.dir ? S_MRD : S_PRD;
                    end
                end
                S_MRD: if (mem_ack) begin
                    if (mem_err) begin
                        flags_q.dberr <= 1'b1;
                        flags_q.done  <= 1'b1;
                        st_q          <= S_IDLE;
                    end else begin
                        byte_q <= mem_rdata[7:0];
                        st_q   <= S_PWR;
                    end
                end
                S_PWR: if (per_ack) begin
                    daddr_q <= daddr_q + AW'(1);
                    len_q   <= len_q - ONE_LEFT;
                    st_q    <= (len_q == ONE_LEFT) ? S_SEGEND : S_MRD;
                end
                S_PRD: if (per_ack) begin
                    byte_q <= per_rdata;
                    st_q   <= S_MWR;
                end
                S_MWR: if (mem_ack) begin
                    if (mem_err) begin
                        flags_q.dberr <= 1'b1;
                        flags_q.done  <= 1'b1;
                        st_q          <= S_IDLE;
                    end else begin
                        daddr_q <= daddr_q + AW'(1);
                        len_q   <= len_q - ONE_LEFT;
                        st_q    <= (len_q == ONE_LEFT) ? S_SEGEND : S_PRD;
                    end
                end
                S_SEGEND: begin
                    if (mode_q.tbl && more_q) begin
                        st_q <= S_FETCH_A;
                    end else begin
                        flags_q.done <= 1'b1;
                        st_q         <= S_IDLE;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign flags  = flags_q;
    assign mode   = mode_q;
    assign busy   = (st_q != S_IDLE);
    assign daddr  = daddr_q;
    assign len    = len_q;
    assign seg_fc = fc_q;
    assign taddr  = taddr_q;

    p_one_bus_r13: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && per_req));
    p_addr_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack && !ctrl_wr) |=> (mem_req && $stable(mem_addr)));
    p_fault_abort_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_fault && !ctrl_wr) |=> (!busy && flags.done));
    p_done_idle_r5: assert property (@(posedge clk) disable iff (rst)
        flags.done |-> !busy);
    p_stop_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !ctrl_val[0]) |=> (!mem_req && !per_req && !flags.done));
endmodule

// File: rtl/dma_sg_engine.sv
module dma_sg_engine
    import dma_sg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int LW = LEN_W,
    parameter int FW = FC_W,
    parameter int VW = LVL_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_we,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_word,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_wdata,
    output logic [FW-1:0] mem_fc,
    input  logic          mem_ack,
    input  logic          mem_err,
    input  logic [DW-1:0] mem_rdata,
    output logic          per_req,
    output logic          per_we,
    output logic [7:0]    per_wdata,
    input  logic [7:0]    per_rdata,
    input  logic          per_ack,
    output logic          irq,
    output logic [VW-1:0] irq_lvl
);
    localparam int CNT_PAD = DW - LW - FW;
    localparam int IRQ_W   = VW + 2;

    logic [FW-1:0]    tfc_q;
    dma_flags_t       flags;
    dma_mode_t        mode;
    logic             busy, done_pulse;
    logic [AW-1:0]    daddr, taddr;
    logic [LW-1:0]    len;
    logic [FW-1:0]    seg_fc;
    logic [IRQ_W-1:0] irq_rd;

    always_ff @(posedge clk) begin
        if (rst)
            tfc_q <= '0;
        else if (reg_we && reg_addr == RA_TFC)
            tfc_q <= reg_wdata[FW-1:0];
    end

    dma_sg_seq #(.AW(AW), .DW(DW), .LW(LW), .FW(FW)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (reg_we && reg_addr == RA_CTRL),
        .ctrl_val  (reg_wdata[2:0]),
        .daddr_wr  (reg_we && reg_addr == RA_DADDR),
        .dcnt_wr   (reg_we && reg_addr == RA_DCNT),
        .taddr_wr  (reg_we && reg_addr == RA_TADDR),
        .wdata     (reg_wdata),
        .tfc       (tfc_q),
        .flags     (flags),
        .mode      (mode),
        .busy      (busy),
        .daddr     (daddr),
        .len       (len),
        .seg_fc    (seg_fc),
        .taddr     (taddr),
        .done_pulse(done_pulse),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_word  (mem_word),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_fc    (mem_fc),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err),
        .mem_rdata (mem_rdata),
        .per_req   (per_req),
        .per_we    (per_we),
        .per_wdata (per_wdata),
        .per_rdata (per_rdata),
        .per_ack   (per_ack)
    );

    dma_sg_irq #(.LW(VW)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_we && reg_addr == RA_IRQ),
        .wdata     (reg_wdata[IRQ_W-1:0]),
        .done_pulse(done_pulse),
        .rdata     (irq_rd),
        .irq       (irq),
        .irq_lvl   (irq_lvl)
    );

    always_comb begin
        case (reg_addr)
            RA_CTRL:  reg_rdata = DW'({flags, mode, busy});
            RA_DADDR: reg_rdata = DW'(daddr);
            RA_DCNT:  reg_rdata = {{CNT_PAD{1'b0}}, seg_fc, len};
            RA_TADDR: reg_rdata = DW'(taddr);
            RA_TFC:   reg_rdata = DW'(tfc_q);
            RA_IRQ:   reg_rdata = DW'(irq_rd);
            default:  reg_rdata = '0;
        endcase
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!mem_req && !per_req && !irq));
endmodule

// File: tb/dma_sg_engine_tb_top.sv
module dma_sg_engine_tb_top;
    import dma_sg_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_word;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [2:0]  mem_fc;
    logic        mem_ack = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        per_req, per_we;
    logic [7:0]  per_wdata;
    logic [7:0]  per_rdata = '0;
    logic        per_ack = 1'b0;
    logic        irq;
    logic [2:0]  irq_lvl;

    always #4 clk = ~clk;

    dma_sg_engine dut_i (.*);

    logic [7:0]  mem [256];
    logic [7:0]  plog [64];
    int          pidx = 0, mem_acc = 0, overlap = 0;
    logic [2:0]  last_dfc = '0, last_tfc = '0;
    logic [31:0] err_addr = 32'hFFFF_FFFF;
    logic [7:0]  ma;
    int          nchk = 0, nerr = 0;

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        mem_err <= 1'b0;
        per_ack <= 1'b0;
        if (mem_req && per_req) overlap++;
        if (mem_req && !mem_ack) begin
            ma = mem_addr[7:0];
            mem_ack <= 1'b1;
            mem_acc++;
            mem_rdata <= {mem[ma+8'd3], mem[ma+8'd2], mem[ma+8'd1], mem[ma]};
            if (mem_addr == err_addr) mem_err <= 1'b1;
            else if (mem_we) mem[ma] <= mem_wdata;
            if (mem_word) last_tfc <= mem_fc; else last_dfc <= mem_fc;
        end
        if (per_req && !per_ack) begin
            per_ack <= 1'b1;
            if (per_we) plog[pidx[5:0]] <= per_wdata;
            per_rdata <= 8'hC0 + pidx[7:0];
            pidx++;
        end
    end

    task automatic report;
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog actual=hung expected=finished");
        report();
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle;
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(RA_CTRL, v);
            if (!v[0]) break;
        end
    endtask

    task automatic init_mem;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    endtask

    task automatic put_word(input int a, input logic [31:0] w);
        for (int k = 0; k < 4; k++) mem[a + k] = w[8*k +: 8];
    endtask

    typedef struct packed {
        logic       dir;
        logic [7:0] addr;
        logic [7:0] len;
        logic [2:0] fc;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{1'b1, 8'h10, 8'd4, 3'd1},
        '{1'b0, 8'h40, 8'd3, 3'd2},
        '{1'b1, 8'hF0, 8'd1, 3'd7},
        '{1'b0, 8'h60, 8'd9, 3'd5}
    };

    initial begin
        logic [31:0] v;
        int          acc0;
        init_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(RA_CTRL, v);  check("R1 ctrl", v, 32'h0);
        rd(RA_DADDR, v); check("R1 daddr", v, 32'h0);
        rd(RA_IRQ, v);   check("R1 irq reg", v, 32'h0);
        check("R1 outputs", {29'b0, irq, mem_req, per_req}, 32'h0);

        wr(RA_IRQ, 32'h0E);  // enable, level 3

        // R2 / R4 / R5 vector walk, direct mode
        foreach (VECS[n]) begin
            init_mem();
            pidx = 0;
            wr(RA_CTRL, 0);
            wr(RA_DADDR, {24'b0, VECS[n].addr});
            wr(RA_DCNT, {5'b0, VECS[n].fc, 16'b0, VECS[n].len});
            wr(RA_CTRL, {29'b0, 1'b0, VECS[n].dir, 1'b1});
            wait_idle();
            rd(RA_CTRL, v);
            check("R5 done status", v, {28'b0, 4'b1000} | {30'b0, VECS[n].dir, 1'b0});
            for (int k = 0; k < int'(VECS[n].len); k++) begin
                if (VECS[n].dir)
                    check("R2 mem->per byte", {24'b0, plog[k]}, {24'b0, (VECS[n].addr + 8'(k)) ^ 8'h5A});
                else
                    check("R2 per->mem byte", {24'b0, mem[VECS[n].addr + 8'(k)]}, {24'b0, 8'hC0 + 8'(k)});
            end
            check("R4 data fc", {29'b0, last_dfc}, {29'b0, VECS[n].fc});
            rd(RA_DADDR, v);
            check("R2 final addr", v, {24'b0, VECS[n].addr} + {24'b0, VECS[n].len});
            rd(RA_DCNT, v);
            check("R2 final count", v, {5'b0, VECS[n].fc, 24'b0});
        end
        check("R6 irq raised", {28'b0, irq_lvl, irq}, {28'b0, 3'd3, 1'b1});
        wr(RA_IRQ, 32'h0F);
        check("R6 irq acked", {31'b0, irq}, 32'h0);

        // R3 table walk: three linked entries, fourth must be ignored
        init_mem();
        put_word(8'h80, 32'h10); put_word(8'h84, 32'h8500_0003);
        put_word(8'h88, 32'h40); put_word(8'h8C, 32'h8500_0002);
        put_word(8'h90, 32'h20); put_word(8'h94, 32'h0500_0001);
        put_word(8'h98, 32'h30); put_word(8'h9C, 32'h0500_0004);
        pidx = 0; mem_acc = 0;
        wr(RA_CTRL, 0);
        wr(RA_TFC, 32'd6);
        wr(RA_TADDR, 32'h80);
        wr(RA_CTRL, 32'h7);
        wait_idle();
        rd(RA_CTRL, v); check("R3 table done", v, 32'h0E);
        check("R3 byte count", pidx, 6);
        check("R3 mem cycles", mem_acc, 12);
        check("R3 b0", {24'b0, plog[0]}, {24'b0, 8'h10 ^ 8'h5A});
        check("R3 b2", {24'b0, plog[2]}, {24'b0, 8'h12 ^ 8'h5A});
        check("R3 b3", {24'b0, plog[3]}, {24'b0, 8'h40 ^ 8'h5A});
        check("R3 b5", {24'b0, plog[5]}, {24'b0, 8'h20 ^ 8'h5A});
        check("R4 fetch fc", {29'b0, last_tfc}, 32'd6);
        check("R4 seg fc", {29'b0, last_dfc}, 32'd5);
        check("R6 irq table", {31'b0, irq}, 32'h1);

        // R6 no interrupt while disabled
        wr(RA_IRQ, 32'h01);
        wr(RA_CTRL, 0);
        wr(RA_DADDR, 32'h50); wr(RA_DCNT, 32'd2);
        wr(RA_CTRL, 32'h3);
        wait_idle();
        repeat (2) @(negedge clk);
        check("R6 masked", {31'b0, irq}, 32'h0);

        // R7 data bus error in mid-segment
        init_mem(); pidx = 0; err_addr = 32'h32;
        wr(RA_CTRL, 0);
        wr(RA_DADDR, 32'h30); wr(RA_DCNT, 32'd5);
        wr(RA_CTRL, 32'h3);
        wait_idle();
        rd(RA_CTRL, v);  check("R7 status", v, 32'h2A);
        rd(RA_DADDR, v); check("R7 fault addr", v, 32'h32);
        rd(RA_DCNT, v);  check("R7 remaining", v, 32'd3);
        check("R7 bytes moved", pidx, 2);

        // R12 control write clears flags
        wr(RA_CTRL, 0);
        rd(RA_CTRL, v); check("R12 flags cleared", v, 32'h0);

        // R8 fetch bus error on count word
        init_mem();
        put_word(8'h80, 32'h10); put_word(8'h84, 32'h0100_0002);
        pidx = 0; err_addr = 32'h84;
        wr(RA_TADDR, 32'h80);
        wr(RA_CTRL, 32'h7);
        wait_idle();
        rd(RA_CTRL, v); check("R8 status", v, 32'h1E);
        check("R8 no data", pidx, 0);
        err_addr = 32'hFFFF_FFFF;

        // R9 zero-length segment
        mem_acc = 0;
        wr(RA_CTRL, 0);
        wr(RA_DADDR, 32'h20); wr(RA_DCNT, 32'h0200_0000);
        wr(RA_CTRL, 32'h3);
        wait_idle();
        rd(RA_CTRL, v); check("R9 status", v, 32'h4A);
        check("R9 no access", mem_acc, 0);

        // R10 misaligned table pointer
        mem_acc = 0;
        wr(RA_CTRL, 0);
        wr(RA_TADDR, 32'h82);
        wr(RA_CTRL, 32'h7);
        wait_idle();
        rd(RA_CTRL, v); check("R10 status", v, 32'h8E);
        check("R10 no access", mem_acc, 0);

        // R11 stop mid-transfer
        wr(RA_IRQ, 32'h0F);
        wr(RA_CTRL, 0);
        wr(RA_DADDR, 32'h40); wr(RA_DCNT, 32'd20);
        wr(RA_CTRL, 32'h1);
        repeat (10) @(negedge clk);
        wr(RA_CTRL, 0);
        rd(RA_CTRL, v); check("R11 stopped", v, 32'h0);
        acc0 = mem_acc;
        repeat (20) @(negedge clk);
        check("R11 no more cycles", mem_acc, acc0);
        check("R11 no irq", {30'b0, irq, mem_req}, 32'h0);

        // R13 bus exclusivity over the whole run
        check("R13 overlap", overlap, 0);

        report();
    end
endmodule